// File: doc/BRIEF.md
# Wake Event and PME Generator

This block merges wake-up indications from two Ethernet PHYs and a host MAC into one power-management-event (PME) pin and one shared interrupt request. A PHY reports an energy-on wake when its energy-on interrupt source is raised and unmasked. The MAC reports a wake when a received wake-up frame or a received magic packet has its matching enable set. Each source sets a sticky status bit. A separate enable per source decides whether that status can drive the PME pin.

The PME pin can either give a timed pulse for each wake event or hold a level while any enabled status is pending. Its active polarity is programmable. It can be driven push-pull, or open-drain through an output enable. The same wake trigger also sets a PME interrupt status. That status is gated onto the IRQ line together with the other system interrupts. Software reads and controls the block through four 32-bit registers that are reached with a two-bit address. Every register resets to zero.

Top module: `pme_wake_gen`

## Requirements
- R1: After reset, every register (address 0 control, 1 interrupt status, 2 interrupt enable, 3 IRQ config) reads 0, `pme_oe` is 0 and `irq_out` is 0.
- R2: PHY n sets its sticky energy status (control bit 16 for PHY 0, bit 17 for PHY 1) on the clock edge where `phy_int_src[n]` and `phy_int_mask[n]` are both 1. The status is not set when the mask is 0.
- R3: The sticky wake-on-LAN status (control bit 5) is set on a clock edge where (`mac_frame_wake_en` AND `mac_frame_wake_rx`) OR (`mac_magic_en` AND `mac_magic_rx`) is true.
- R4: A sticky status bit stays set until software writes 1 to its bit position. Writing 0 leaves it unchanged. A new event in the same cycle as the clearing write wins.
- R5: Pulse mode (control bit 3 = 1). A trigger makes the pin active for exactly PULSE_MS milliseconds of clock cycles, starting the cycle after the trigger. A trigger during an active pulse restarts the full width.
- R6: Level mode (control bit 3 = 0). The pin is active while PME enable (control bit 1) is 1 and any status whose enable is set is 1. The enables are bit 14 (PHY 0), bit 15 (PHY 1) and bit 9 (wake-on-LAN).
- R7: A trigger is an enabled source event in a cycle with PME enable set. A source whose enable is 0 still sets its status, but it neither activates the pin nor sets the PME interrupt status.
- R8: Control bit 2 selects the active pin level: 1 means active-high and 0 means active-low.
- R9: Control bit 6 = 1 selects push-pull, where `pme_oe` is always 1. Bit 6 = 0 selects open-drain, where `pme_oe` equals pin-active and `pme_out` carries the active level.
- R10: A trigger sets the PME interrupt status (address 1 bit 17). The status is cleared by writing 1 to that bit.
- R11: `irq_out` = IRQ enable (address 3 bit 8) AND ((PME interrupt status AND PME interrupt enable at address 2 bit 17) OR `sys_irq_in`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| phy_int_src | input | 2 | Per-PHY energy-on interrupt source |
| phy_int_mask | input | 2 | Per-PHY energy-on interrupt mask (1 = unmasked) |
| mac_frame_wake_en | input | 1 | MAC wake-up-frame enable |
| mac_frame_wake_rx | input | 1 | MAC wake-up-frame received |
| mac_magic_en | input | 1 | MAC magic-packet enable |
| mac_magic_rx | input | 1 | MAC magic-packet received |
| sys_irq_in | input | 1 | Other system interrupts |
| pme_out | output | 1 | PME pin data |
| pme_oe | output | 1 | PME pin output enable |
| irq_out | output | 1 | Shared interrupt request |

## Verification
The bench measures the pulse width directly, including a retrigger partway through a pulse. An off-by-one counter would lengthen or shorten the pulse, and a design that ignored retriggers would cut it short. It collides a write-1-to-clear with a fresh event to catch a design that drops the new wake. It drives a PHY event with the mask clear, and an event from a disabled source. A design that confused the mask with the enable would set a status, fire the pin or raise an interrupt where it should not. Long random runs also switch polarity, mode and buffer type while statuses are pending, which exposes a wrong open-drain release or an inverted pin.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int N_PHY = 2;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_INT_STS = 2'd1,
    REG_INT_EN  = 2'd2,
    REG_IRQ_CFG = 2'd3
  } reg_sel_e;

  localparam int B_PME_EN   = 1;
  localparam int B_POL      = 2;
  localparam int B_MODE     = 3;
  localparam int B_WOL_STS  = 5;
  localparam int B_BUF      = 6;
  localparam int B_IRQ_EN   = 8;
  localparam int B_WOL_EN   = 9;
  localparam int B_ED_EN0   = 14;
  localparam int B_ED_STS0  = 16;
  localparam int B_PME_INT  = 17;
endpackage

// File: rtl/pme_wake_status.sv
module pme_wake_status
  import pme_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PHY-1:0] ed_src_i,
  input  logic [N_PHY-1:0] ed_mask_i,
  input  logic [N_PHY-1:0] ed_en_i,
  input  logic [N_PHY-1:0] ed_clr_i,
  input  logic             wuf_en_i,
  input  logic             wuf_rx_i,
  input  logic             mp_en_i,
  input  logic             mp_rx_i,
  input  logic             wol_en_i,
  input  logic             wol_clr_i,
  input  logic             pme_en_i,
  output logic [N_PHY-1:0] ed_sts_o,
  output logic             wol_sts_o,
  output logic             trig_o,
  output logic             lvl_o
);
  logic [N_PHY-1:0] ed_evt;
  logic [N_PHY-1:0] ed_sts_q, ed_sts_d;
  logic             wol_evt, wol_sts_q, wol_sts_d;

  for (genvar i = 0; i < N_PHY; i++) begin : g_phy
    assign ed_evt[i] = ed_src_i[i] & ed_mask_i[i];

    always_comb begin
      ed_sts_d[i] = ed_sts_q[i];
      if (ed_clr_i[i]) ed_sts_d[i] = 1'b0;
      if (ed_evt[i])   ed_sts_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ed_sts_q[i] <= 1'b0;
      else        ed_sts_q[i] <= ed_sts_d[i];
    end

    a_r4_ed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ed_sts_q[i] && !ed_clr_i[i]) |=> ed_sts_q[i]);
    a_r2_ed_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ed_src_i[i] && ed_mask_i[i]) |=> ed_sts_q[i]);
  end

  assign wol_evt = (wuf_en_i & wuf_rx_i) | (mp_en_i & mp_rx_i);

  always_comb begin
    wol_sts_d = wol_sts_q;
    if (wol_clr_i) wol_sts_d = 1'b0;
    if (wol_evt)   wol_sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wol_sts_q <= 1'b0;
    else        wol_sts_q <= wol_sts_d;
  end

  assign trig_o    = pme_en_i & ((|(ed_evt & ed_en_i)) | (wol_evt & wol_en_i));
  assign lvl_o     = (|(ed_sts_q & ed_en_i)) | (wol_sts_q & wol_en_i);
  assign ed_sts_o  = ed_sts_q;
  assign wol_sts_o = wol_sts_q;

  a_r3_wol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_en_i && mp_rx_i) |=> wol_sts_q);
  a_r4_wol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wol_sts_q && !wol_clr_i) |=> wol_sts_q);
endmodule

// File: rtl/pme_pulse_timer.sv
module pme_pulse_timer #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PULSE_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic busy_o
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;
  localparam int CNT_W     = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = trig_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (trig_i)            cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_q == CNT_W'(PULSE_CYC)));
  a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !trig_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !trig_i) |=> !busy_o);
endmodule

// File: rtl/pme_pin_drive.sv
module pme_pin_drive (
  input  logic active_i,
  input  logic pol_high_i,
  input  logic push_pull_i,
  output logic pme_o,
  output logic pme_oe_o
);
  always_comb begin
    pme_o    = pol_high_i ? active_i : ~active_i;
    pme_oe_o = push_pull_i | active_i;
  end
endmodule

// File: rtl/pme_wake_gen.sv
module pme_wake_gen
  import pme_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PULSE_MS = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [N_PHY-1:0]    phy_int_src,
  input  logic [N_PHY-1:0]    phy_int_mask,
  input  logic                mac_frame_wake_en,
  input  logic                mac_frame_wake_rx,
  input  logic                mac_magic_en,
  input  logic                mac_magic_rx,
  input  logic                sys_irq_in,
  output logic                pme_out,
  output logic                pme_oe,
  output logic                irq_out
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             wr_ctrl, wr_ists, wr_ien, wr_icfg;
  logic             pme_en_q, pol_q, mode_pulse_q, push_pull_q, wol_en_q;
  logic [N_PHY-1:0] ed_en_q;
  logic             int_en_q, irq_en_q, pme_int_q, pme_int_d;
  logic [N_PHY-1:0] ed_sts, ed_clr;
  logic             wol_sts, wol_clr, trig, lvl, busy, active;

  assign wr_ctrl = wr_en & (addr == REG_CTRL);
  assign wr_ists = wr_en & (addr == REG_INT_STS);
  assign wr_ien  = wr_en & (addr == REG_INT_EN);
  assign wr_icfg = wr_en & (addr == REG_IRQ_CFG);

  assign ed_clr  = {N_PHY{wr_ctrl}} & wdata[B_ED_STS0 +: N_PHY];
  assign wol_clr = wr_ctrl & wdata[B_WOL_STS];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pme_en_q     <= 1'b0;
      pol_q        <= 1'b0;
      mode_pulse_q <= 1'b0;
      push_pull_q  <= 1'b0;
      wol_en_q     <= 1'b0;
      ed_en_q      <= '0;
    end else if (wr_ctrl) begin
      pme_en_q     <= wdata[B_PME_EN];
      pol_q        <= wdata[B_POL];
      mode_pulse_q <= wdata[B_MODE];
      push_pull_q  <= wdata[B_BUF];
      wol_en_q     <= wdata[B_WOL_EN];
      ed_en_q      <= wdata[B_ED_EN0 +: N_PHY];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  int_en_q <= 1'b0;
    else if (wr_ien)  int_en_q <= wdata[B_PME_INT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  irq_en_q <= 1'b0;
    else if (wr_icfg) irq_en_q <= wdata[B_IRQ_EN];
  end

  always_comb begin
    pme_int_d = pme_int_q;
    if (wr_ists && wdata[B_PME_INT]) pme_int_d = 1'b0;
    if (trig)                        pme_int_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pme_int_q <= 1'b0;
    else             pme_int_q <= pme_int_d;
  end

  pme_wake_status u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ed_src_i  (phy_int_src),
    .ed_mask_i (phy_int_mask),
    .ed_en_i   (ed_en_q),
    .ed_clr_i  (ed_clr),
    .wuf_en_i  (mac_frame_wake_en),
    .wuf_rx_i  (mac_frame_wake_rx),
    .mp_en_i   (mac_magic_en),
    .mp_rx_i   (mac_magic_rx),
    .wol_en_i  (wol_en_q),
    .wol_clr_i (wol_clr),
    .pme_en_i  (pme_en_q),
    .ed_sts_o  (ed_sts),
    .wol_sts_o (wol_sts),
    .trig_o    (trig),
    .lvl_o     (lvl)
  );

  pme_pulse_timer #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trig_i (trig),
    .busy_o (busy)
  );

  assign active = pme_en_q & (mode_pulse_q ? busy : lvl);

  pme_pin_drive u_pin (
    .active_i    (active),
    .pol_high_i  (pol_q),
    .push_pull_i (push_pull_q),
    .pme_o       (pme_out),
    .pme_oe_o    (pme_oe)
  );

  assign irq_out = irq_en_q & ((pme_int_q & int_en_q) | sys_irq_in);

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CTRL: begin
        rdata[B_PME_EN]             = pme_en_q;
        rdata[B_POL]                = pol_q;
        rdata[B_MODE]               = mode_pulse_q;
        rdata[B_WOL_STS]            = wol_sts;
        rdata[B_BUF]                = push_pull_q;
        rdata[B_WOL_EN]             = wol_en_q;
        rdata[B_ED_EN0 +: N_PHY]    = ed_en_q;
        rdata[B_ED_STS0 +: N_PHY]   = ed_sts;
      end
      REG_INT_STS: rdata[B_PME_INT] = pme_int_q;
      REG_INT_EN:  rdata[B_PME_INT] = int_en_q;
      default:     rdata[B_IRQ_EN]  = irq_en_q;
    endcase
  end

  a_r10_int_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig |=> pme_int_q);
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_en_q |-> !irq_out);
  a_r9_push_pull_drives: assert property (@(posedge clk) disable iff (!rst_sync_n)
    push_pull_q |-> pme_oe);
  a_r7_no_pme_when_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pme_en_q && !push_pull_q) |-> !pme_oe);
endmodule

// File: tb/tb_pme_wake_gen.sv
module tb_pme_wake_gen;
  localparam int CLK_HZ   = 1000;
  localparam int PULSE_MS = 20;
  localparam int PULSE    = (CLK_HZ / 1000) * PULSE_MS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  phy_int_src = '0, phy_int_mask = '0;
  logic        mac_frame_wake_en = 0, mac_frame_wake_rx = 0;
  logic        mac_magic_en = 0, mac_magic_rx = 0, sys_irq_in = 0;
  logic        pme_out, pme_oe, irq_out;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pme_wake_gen #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .phy_int_src(phy_int_src), .phy_int_mask(phy_int_mask),
    .mac_frame_wake_en(mac_frame_wake_en), .mac_frame_wake_rx(mac_frame_wake_rx),
    .mac_magic_en(mac_magic_en), .mac_magic_rx(mac_magic_rx),
    .sys_irq_in(sys_irq_in), .pme_out(pme_out), .pme_oe(pme_oe), .irq_out(irq_out)
  );

  // Behavioural reference state
  bit m_pme_en, m_pol, m_pulse, m_pp, m_wol_en, m_en0, m_en1;
  bit m_ed0, m_ed1, m_wol, m_int, m_int_en, m_irq_en;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_pme_en, m_pol, m_pulse, m_pp, m_wol_en, m_en0, m_en1} = '0;
      {m_ed0, m_ed1, m_wol, m_int, m_int_en, m_irq_en} = '0;
      m_cnt = 0;
    end else begin
      bit e0, e1, ew, tr, w0, w1;
      e0 = phy_int_src[0] && phy_int_mask[0];
      e1 = phy_int_src[1] && phy_int_mask[1];
      ew = (mac_frame_wake_en && mac_frame_wake_rx) || (mac_magic_en && mac_magic_rx);
      tr = m_pme_en && ((m_en0 && e0) || (m_en1 && e1) || (m_wol_en && ew));
      w0 = wr_en && addr == 2'd0;
      w1 = wr_en && addr == 2'd1;
      m_ed0 = e0 || (m_ed0 && !(w0 && wdata[16]));
      m_ed1 = e1 || (m_ed1 && !(w0 && wdata[17]));
      m_wol = ew || (m_wol && !(w0 && wdata[5]));
      m_int = tr || (m_int && !(w1 && wdata[17]));
      if (tr) m_cnt = PULSE;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (w0) begin
        m_pme_en = wdata[1]; m_pol = wdata[2]; m_pulse = wdata[3];
        m_pp = wdata[6]; m_wol_en = wdata[9]; m_en0 = wdata[14]; m_en1 = wdata[15];
      end
      if (wr_en && addr == 2'd2) m_int_en = wdata[17];
      if (wr_en && addr == 2'd3) m_irq_en = wdata[8];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act_v;
      logic [31:0] er;
      act_v = m_pme_en && (m_pulse ? (m_cnt > 0)
              : ((m_en0 && m_ed0) || (m_en1 && m_ed1) || (m_wol_en && m_wol)));
      chk(m_pulse ? "R5 pme_out pulse" : "R6 pme_out level", pme_out, m_pol ? act_v : !act_v);
      chk("R9 pme_oe", pme_oe, m_pp || act_v);
      chk("R11 irq_out", irq_out, m_irq_en && ((m_int && m_int_en) || sys_irq_in));
      er = '0;
      case (addr)
        2'd0: begin
          er[1] = m_pme_en; er[2] = m_pol; er[3] = m_pulse; er[5] = m_wol; er[6] = m_pp;
          er[9] = m_wol_en; er[14] = m_en0; er[15] = m_en1; er[16] = m_ed0; er[17] = m_ed1;
        end
        2'd1: er[17] = m_int;
        2'd2: er[17] = m_int_en;
        default: er[8] = m_irq_en;
      endcase
      chk("R4 rdata", rdata, er);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    tick(); wr_en = 1; addr = a; wdata = d;
    tick(); wr_en = 0; wdata = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(150_000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hi;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 reset reg", rdata, 32'h0);
    end
    chk("R1 reset oe", pme_oe, 0);
    chk("R1 reset irq", irq_out, 0);

    // pulse mode, active-high, push-pull, PHY0 enabled
    wr(2'd0, (1<<1)|(1<<2)|(1<<3)|(1<<6)|(1<<14));
    addr = 2'd0;
    phy_int_src[0] = 1; phy_int_mask[0] = 1;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (i == 0) phy_int_src[0] = 0;
      if (pme_out) hi++;
    end
    chk("R5 pulse width", hi, PULSE);
    chk("R2 PHY0 status", rdata[16], 1);

    // retrigger mid-pulse
    phy_int_src[0] = 1; hi = 0;
    for (int i = 1; i <= 60; i++) begin
      tick();
      if (i == 1) phy_int_src[0] = 0;
      if (i == 10) phy_int_src[0] = 1;
      if (i == 11) phy_int_src[0] = 0;
      if (pme_out) hi++;
    end
    chk("R5 retrigger width", hi, 30);

    // masked PHY1 source does not set status
    phy_int_src[1] = 1; phy_int_mask[1] = 0;
    tick(); tick(); phy_int_src[1] = 0;
    chk("R2 masked PHY1", rdata[17], 0);

    // disabled PHY1: status sets, no pme, no interrupt
    wr(2'd1, 1<<17);
    addr = 2'd0;
    phy_int_src[1] = 1; phy_int_mask[1] = 1;
    tick(); phy_int_src[1] = 0; hi = 0;
    for (int i = 0; i < 5; i++) begin tick(); if (pme_out) hi++; end
    chk("R7 disabled status set", rdata[17], 1);
    chk("R7 disabled no pme", hi, 0);
    addr = 2'd1; #1;
    chk("R7 disabled no int", rdata[17], 0);

    // level mode, active-low, open-drain, WOL via magic packet
    wr(2'd0, (1<<1)|(1<<9)|(1<<16)|(1<<17)|(1<<5));
    addr = 2'd0;
    mac_magic_en = 1; mac_magic_rx = 1;
    tick(); mac_magic_rx = 0;
    tick();
    chk("R3 wol status", rdata[5], 1);
    chk("R8 active low", pme_out, 0);
    chk("R9 open-drain drive", pme_oe, 1);
    wr(2'd0, (1<<1)|(1<<9));
    tick();
    chk("R4 write 0 keeps", rdata[5], 1);
    // clear collides with new frame wake
    mac_frame_wake_en = 1; mac_frame_wake_rx = 1;
    wr(2'd0, (1<<1)|(1<<9)|(1<<5));
    mac_frame_wake_rx = 0;
    chk("R4 set beats clear", rdata[5], 1);
    wr(2'd0, (1<<1)|(1<<9)|(1<<5));
    tick();
    chk("R6 level released", rdata[5], 0);
    chk("R9 open-drain release", pme_oe, 0);

    // interrupt routing
    wr(2'd2, 1<<17);
    wr(2'd3, 1<<8);
    chk("R11 irq from pme int", irq_out, 1);
    wr(2'd1, 1<<17);
    tick();
    chk("R10 int cleared", irq_out, 0);
    sys_irq_in = 1; #1;
    chk("R11 other irq", irq_out, 1);
    sys_irq_in = 0;

    // randomized traffic, compared each cycle against the reference
    for (int i = 0; i < 20000; i++) begin
      tick();
      phy_int_src  = 2'($urandom_range(0, 3)) & {($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0)};
      phy_int_mask = 2'($urandom_range(0, 3));
      mac_frame_wake_en = 1'($urandom_range(0, 1));
      mac_frame_wake_rx = ($urandom_range(0, 31) == 0);
      mac_magic_en = 1'($urandom_range(0, 1));
      mac_magic_rx = ($urandom_range(0, 31) == 0);
      sys_irq_in = ($urandom_range(0, 7) == 0);
      addr = 2'($urandom_range(0, 3));
      wr_en = ($urandom_range(0, 7) == 0);
      wdata = $urandom();
    end
    tick(); wr_en = 0;
    tick();
    finish_run();
  end
endmodule